// File: doc/BRIEF.md
# Serial Character Transmitter with Idle Sync Fill

This block is the sending side of a programmable serial port. A processor drops an 8-bit character into a one-entry holding register. The block moves it into a shift register and clocks it out on a single serial line. Bit timing comes from an external transmit clock. That clock is sampled in the system clock domain, and the line may change only when a falling edge of it is seen.

Two framings are available. In asynchronous mode each character goes out as one low start bit, the eight data bits least significant first, and one high stop bit. Each bit lasts 1, 16 or 64 transmit-clock periods. In synchronous mode the eight data bits go out back to back, one per transmit-clock period. Whenever no character is waiting, the block repeats a programmable fill character instead. Two command inputs control the line. An enable input gates all sending. A break input pins the line low. Two status outputs tell the processor when it may write again and when nothing useful is left to send.

Top module: `usart_tx_sync_fill`

## Requirements
- R1: While `rst` is high and after its release, `txd` is 1, `tx_rdy` is 1 and `tx_empty` is 1.
- R2: A cycle with `wr_en` high stores `wr_data` and drives `tx_rdy` low from the next clock. `tx_rdy` returns high at the transmit-clock falling edge that moves the character into the shift register. `tx_rdy` never falls without a write.
- R3: With `cfg_sync_mode`=0, a character goes out as a frame in this order: start bit 0, `wr_data[0]` through `wr_data[7]`, then stop bit 1.
- R4: With `cfg_sync_mode`=0, each bit lasts this many transmit-clock falling edges: 1 when `cfg_rate`=2'b00, 16 when `cfg_rate`=2'b01, and 64 when `cfg_rate` is 2'b10 or 2'b11.
- R5: While `cmd_tx_en` is 1 and `cmd_break` stays 0, `txd` changes only in the clock after a falling edge of `txc` is seen. A falling edge is `txc` at 1 in one system clock and at 0 in the next.
- R6: While `cmd_tx_en` is 0, `txd` is 1 from the next clock. Any frame in progress is dropped. A character written in this state stays held, with `tx_rdy` low, until `cmd_tx_en` returns. It then starts at the next falling edge.
- R7: While `cmd_break` is 1, `txd` is 0 from the next clock, whatever the mode or the enable. When `cmd_break` returns to 0, the line goes back to the normal output.
- R8: With `cfg_sync_mode`=1, a character goes out as eight bits, `wr_data[0]` first, one bit per falling edge, with no start or stop bit. `cfg_rate` is ignored.
- R9: With `cfg_sync_mode`=1 and `cmd_tx_en`=1, when no character is held at a character boundary, `cfg_sync_char` is sent, bit 0 first. `tx_empty` is 1 while it is sent.
- R10: In asynchronous mode, `tx_empty` is 1 exactly when the holding register is empty and the shifter has no frame in progress. The stop bit counts as in progress. `tx_empty` high implies `tx_rdy` high.
- R11: A character written before the current frame ends starts at the first falling edge after the stop bit, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| txc | input | 1 | Transmit clock, sampled by `clk` |
| cfg_sync_mode | input | 1 | 1 selects synchronous framing |
| cfg_rate | input | 2 | Transmit clocks per bit in asynchronous mode (00:1, 01:16, 1x:64) |
| cfg_sync_char | input | 8 | Fill character for synchronous idle |
| cmd_tx_en | input | 1 | Transmit enable |
| cmd_break | input | 1 | Force the line low |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial data line |
| tx_rdy | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Nothing pending (synchronous: fill in progress) |

## Verification
Suppose the bit counter or the rate divider holds a wrong value. Then the next bit after the falling edge of that bit boundary appears on `txd` at the wrong time or with the wrong value. The bench catches this within one bit period, because it compares `txd` after every transmit-clock edge. A stuck holding-full flag shows on `tx_rdy` one clock after the loading edge. A lost fill or busy flag flips `tx_empty` at the character boundary where it is next consulted. A framing error shifts every later bit of the character, so it shows within the same frame.

// File: rtl/usart_tx_sync_fill.sv
module usart_tx_sync_fill (
  input  logic       clk,
  input  logic       rst,
  input  logic       txc,
  input  logic       cfg_sync_mode,
  input  logic [1:0] cfg_rate,
  input  logic [7:0] cfg_sync_char,
  input  logic       cmd_tx_en,
  input  logic       cmd_break,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       tx_rdy,
  output logic       tx_empty
);

  localparam int CW   = 8;
  localparam int FW   = CW + 2;
  localparam int BLW  = $clog2(FW);
  localparam int DIVW = 6;

  logic            txc_d;
  logic [CW-1:0]   hold;
  logic            hold_full;
  logic [FW-1:0]   shreg;
  logic [BLW-1:0]  bits_left;
  logic [DIVW-1:0] div_cnt;
  logic            busy, fill, data_bit, line_r;
  logic            bit_next;
  logic [DIVW-1:0] div_top;

  wire fall      = txc_d & ~txc;
  wire boundary  = fall && (div_cnt == '0);
  wire shifting  = boundary && (bits_left != '0);
  wire load_data = boundary && (bits_left == '0) && hold_full;
  wire load_fill = boundary && (bits_left == '0) && !hold_full && cfg_sync_mode;

  always_comb begin
    if (cfg_sync_mode)          div_top = '0;
    else if (cfg_rate == 2'b00) div_top = '0;
    else if (cfg_rate == 2'b01) div_top = DIVW'(15);
    else                        div_top = DIVW'(63);
  end

  always_comb begin
    bit_next = data_bit;
    if (shifting)       bit_next = shreg[0];
    else if (load_data) bit_next = cfg_sync_mode ? hold[0] : 1'b0;
    else if (load_fill) bit_next = cfg_sync_char[0];
    else if (boundary)  bit_next = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txc_d     <= 1'b0;
      hold      <= '0;
      hold_full <= 1'b0;
      shreg     <= '0;
      bits_left <= '0;
      div_cnt   <= '0;
      busy      <= 1'b0;
      fill      <= 1'b0;
      data_bit  <= 1'b1;
      line_r    <= 1'b1;
    end else begin
      txc_d  <= txc;
      line_r <= cmd_break ? 1'b0 : (cmd_tx_en ? bit_next : 1'b1);
      if (!cmd_tx_en) begin
        busy      <= 1'b0;
        fill      <= 1'b0;
        bits_left <= '0;
        div_cnt   <= '0;
        data_bit  <= 1'b1;
      end else if (fall) begin
        data_bit <= bit_next;
        if (div_cnt != '0) begin
          div_cnt <= div_cnt - 1'b1;
        end else if (shifting) begin
          shreg     <= shreg >> 1;
          bits_left <= bits_left - 1'b1;
          div_cnt   <= div_top;
        end else if (load_data) begin
          hold_full <= 1'b0;
          busy      <= 1'b1;
          fill      <= 1'b0;
          div_cnt   <= div_top;
          if (cfg_sync_mode) begin
            shreg     <= FW'(hold >> 1);
            bits_left <= BLW'(CW - 1);
          end else begin
            shreg     <= FW'({1'b1, hold} );
            bits_left <= BLW'(FW - 1);
          end
        end else if (load_fill) begin
          busy      <= 1'b1;
          fill      <= 1'b1;
          div_cnt   <= div_top;
          shreg     <= FW'(cfg_sync_char >> 1);
          bits_left <= BLW'(CW - 1);
        end else begin
          busy <= 1'b0;
          fill <= 1'b0;
        end
      end
      if (wr_en) begin
        hold      <= wr_data;
        hold_full <= 1'b1;
      end
    end
  end

  assign txd      = line_r;
  assign tx_rdy   = ~hold_full;
  assign tx_empty = ~hold_full & (~busy | fill);

endmodule

module usart_tx_sync_fill_chk (
  input logic clk,
  input logic rst,
  input logic txc,
  input logic cmd_tx_en,
  input logic cmd_break,
  input logic wr_en,
  input logic txd,
  input logic tx_rdy,
  input logic tx_empty
);

  logic txc_q, brk_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      txc_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      txc_q <= txc;
      brk_q <= cmd_break;
    end
  end

  // R2
  write_blocks_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tx_rdy);

  // R2
  rdy_falls_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_rdy) |-> $past(wr_en));

  // R6
  disabled_marks_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_tx_en && !cmd_break) |=> txd);

  // R7
  break_low_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_break |=> !txd);

  // R5
  no_edge_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (!(txc_q && !txc) && cmd_tx_en && !cmd_break && !brk_q) |=> $stable(txd));

  // R10
  empty_implies_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> tx_rdy);

endmodule

bind usart_tx_sync_fill usart_tx_sync_fill_chk u_chk (
  .clk(clk), .rst(rst), .txc(txc), .cmd_tx_en(cmd_tx_en),
  .cmd_break(cmd_break), .wr_en(wr_en), .txd(txd),
  .tx_rdy(tx_rdy), .tx_empty(tx_empty)
);

// File: tb/tb_usart_tx_sync_fill.sv
`timescale 1ns/1ps
module tb_usart_tx_sync_fill;

  logic clk = 1'b0;
  logic rst, txc, cfg_sync_mode, cmd_tx_en, cmd_break, wr_en;
  logic [1:0] cfg_rate;
  logic [7:0] cfg_sync_char, wr_data;
  logic txd, tx_rdy, tx_empty;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  usart_tx_sync_fill dut (
    .clk(clk), .rst(rst), .txc(txc), .cfg_sync_mode(cfg_sync_mode),
    .cfg_rate(cfg_rate), .cfg_sync_char(cfg_sync_char),
    .cmd_tx_en(cmd_tx_en), .cmd_break(cmd_break),
    .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
  );

  function automatic logic frame_bit(input logic [7:0] d, input int k);
    if (k == 0) return 1'b0;
    if (k == 9) return 1'b1;
    return d[k-1];
  endfunction

  function automatic int bit_len(input logic [1:0] r);
    if (r == 2'b00) return 1;
    if (r == 2'b01) return 16;
    return 64;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic tick;
    @(negedge clk) txc = 1'b1;
    @(negedge clk) txc = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_char(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
    chk("R2", {7'd0, tx_rdy}, 8'd0);
  endtask

  task automatic send_frame(input logic [7:0] d, input int n, input bit more, input logic [7:0] nd);
    string tag;
    tag = (n == 1) ? "R3" : "R4";
    for (int k = 0; k < 10; k++) begin
      for (int t = 0; t < n; t++) begin
        tick();
        chk(tag, {7'd0, txd}, {7'd0, frame_bit(d, k)});
        if (k == 0 && t == 0) begin
          chk("R2", {7'd0, tx_rdy}, 8'd1);
          if (more) write_char(nd);
        end
        if (k == 5 && t == 0) chk("R10", {7'd0, tx_empty}, 8'd0);
        if (k == 4 && t == 0) begin
          for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            chk("R5", {7'd0, txd}, {7'd0, frame_bit(d, 4)});
          end
        end
      end
    end
  endtask

  task automatic burst(input logic [1:0] r, input int cnt);
    logic [7:0] cur, nxt;
    cfg_rate = r;
    cur = 8'($urandom);
    write_char(cur);
    for (int i = 0; i < cnt; i++) begin
      nxt = 8'($urandom);
      send_frame(cur, bit_len(r), i < cnt - 1, nxt);
      cur = nxt;
    end
    tick();
    chk("R10", {7'd0, tx_empty}, 8'd1);
    chk("R11", {7'd0, txd}, 8'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    void'($urandom(32'h5eed));
    rst = 1'b1; txc = 1'b0; cfg_sync_mode = 1'b0; cfg_rate = 2'b00;
    cfg_sync_char = 8'h00; cmd_tx_en = 1'b0; cmd_break = 1'b0;
    wr_en = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", {5'd0, txd, tx_rdy, tx_empty}, 8'h07);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {5'd0, txd, tx_rdy, tx_empty}, 8'h07);

    cmd_tx_en = 1'b1;
    // R3 single frame, R10 empty after stop
    write_char(8'hA5);
    send_frame(8'hA5, 1, 1'b0, 8'h00);
    tick();
    chk("R10", {7'd0, tx_empty}, 8'd1);
    // R4 rates 16 and 64
    cfg_rate = 2'b01;
    write_char(8'h3C);
    send_frame(8'h3C, 16, 1'b0, 8'h00);
    tick();
    cfg_rate = 2'b11;
    write_char(8'h81);
    send_frame(8'h81, 64, 1'b0, 8'h00);
    tick();
    chk("R4", {7'd0, txd}, 8'd1);
    // R11 back-to-back random
    burst(2'b00, 8);
    burst(2'b01, 3);
    cfg_rate = 2'b00;

    // R6 disable mid-frame
    write_char(8'hC3);
    repeat (3) tick();
    @(negedge clk) cmd_tx_en = 1'b0;
    @(negedge clk);
    chk("R6", {7'd0, txd}, 8'd1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6", {7'd0, txd}, 8'd1);
    end
    chk("R6", {7'd0, tx_rdy}, 8'd1);
    write_char(8'h5A);
    for (int i = 0; i < 2; i++) begin
      tick();
      chk("R6", {6'd0, txd, tx_rdy}, 8'h02);
    end
    @(negedge clk) cmd_tx_en = 1'b1;
    send_frame(8'h5A, 1, 1'b0, 8'h00);
    tick();

    // R7 break
    @(negedge clk) cmd_break = 1'b1;
    @(negedge clk);
    chk("R7", {7'd0, txd}, 8'd0);
    write_char(8'hFF);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R7", {7'd0, txd}, 8'd0);
    end
    @(negedge clk) cmd_break = 1'b0;
    @(negedge clk);
    chk("R7", {7'd0, txd}, 8'd1);
    for (int i = 0; i < 6; i++) tick();
    chk("R7", {7'd0, txd}, 8'd1);
    tick();
    chk("R10", {7'd0, tx_empty}, 8'd1);

    // R8 / R9 synchronous mode with fill
    for (int rep = 0; rep < 3; rep++) begin
      s = 8'($urandom);
      d = 8'($urandom);
      cfg_sync_char = s;
      cfg_sync_mode = 1'b1;
      cfg_rate = 2'($urandom);
      for (int b = 0; b < 8; b++) begin
        tick();
        chk("R9", {7'd0, txd}, {7'd0, s[b]});
        chk("R9", {7'd0, tx_empty}, 8'd1);
      end
      for (int b = 0; b < 8; b++) begin
        tick();
        chk("R9", {7'd0, txd}, {7'd0, s[b]});
        if (b == 2) begin
          write_char(d);
          chk("R9", {7'd0, tx_empty}, 8'd0);
        end
      end
      for (int b = 0; b < 8; b++) begin
        tick();
        chk("R8", {7'd0, txd}, {7'd0, d[b]});
        chk("R8", {6'd0, tx_rdy, tx_empty}, 8'h02);
      end
      tick();
      chk("R9", {6'd0, txd, tx_empty}, {6'd0, s[0], 1'b1});
      for (int b = 1; b < 8; b++) tick();
      @(negedge clk) cmd_tx_en = 1'b0;
      @(negedge clk) cmd_tx_en = 1'b1;
    end

    done = 1;
    report();
    $finish;
  end

endmodule